// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block takes a 32-bit IEEE-754 single-precision word and produces the 16-bit half-precision word nearest to it under one of four selectable rounding directions. Rounding is done once, on the single-precision fraction, before the result's range is examined. The unit first adds one unit at the kept least-significant position when the rounding rule calls for it. It then classifies the rounded exponent into five outcomes: flush to zero, subnormal, normal, saturate to infinity, or special pass-through.

Because the increment happens before classification, a result that lands in the subnormal range is only shifted afterwards. It is not rounded a second time. Overflow always produces infinity, whatever rounding direction is selected. The output is registered once by default. A parameter can remove the register for a purely combinational path.

Top module: `f2h_narrow`

## Requirements
- R1: Output bit 15 equals input bit 31 in every case.
- R2: No increment is applied when input exponent bits 30:23 are all zeros or all ones. An all-zero input exponent yields a signed zero.
- R3: With rnd_mode = 1 (toward zero) the discarded fraction bits 12:0 are dropped and never cause an increment.
- R4: With rnd_mode = 3 (toward +inf) an increment happens when any of bits 12:0 is set and the sign is 0. With rnd_mode = 2 (toward -inf) an increment happens when any of bits 12:0 is set and the sign is 1.
- R5: With rnd_mode = 0 (nearest-even) an increment happens when bit 12 is set and at least one of bit 13, bit 11 or bits 10:0 is set.
- R6: The increment adds 1 at bit 13 of the word, so a carry out of the fraction raises the exponent by one.
- R7: A rounded biased exponent below 103 gives signed zero.
- R8: A rounded biased exponent from 103 to 112 gives a subnormal. Its 10-bit field is {1, bits 22:13} shifted right by (113 - exponent), with no further rounding.
- R9: A rounded biased exponent from 113 to 142 gives a normal with half exponent (exponent - 112) and fraction bits 22:13.
- R10: A rounded biased exponent from 143 to 254 gives signed infinity (0x7C00 magnitude) in every rounding mode.
- R11: An all-ones input exponent gives half exponent 0x1F with fraction equal to input bits 22:13. A NaN payload confined to bits 12:0 therefore becomes infinity.
- R12: With the output register present, the result appears one clock after the input, and reset clears the output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output |
| in_word | input | 32 | Single-precision operand |
| rnd_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward -inf, 3 toward +inf |
| out_half | output | 16 | Half-precision result |

## Verification
The operand exponent is swept across every range boundary (102/103, 112/113, 142/143, 254/255, and 0) in all four rounding modes. Each exponent is paired with fraction patterns that place the guard, round and sticky bits in every combination, with both signs, so that each rounding rule is separated from its neighbours. Fractions of all ones in bits 22:13 force the carry into the exponent, and that carry moves a value across a class boundary. A low-payload NaN shows that the special case ignores bits 12:0. Pseudo-random words are added on top of the sweep.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
   localparam int SGL_EXP_W  = 8;
   localparam int SGL_FRAC_W = 23;
   localparam int HLF_EXP_W  = 5;
   localparam int HLF_FRAC_W = 10;
   localparam int SGL_W      = 1 + SGL_EXP_W + SGL_FRAC_W;
   localparam int HLF_W      = 1 + HLF_EXP_W + HLF_FRAC_W;
   localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
   localparam int HLF_BIAS   = (1 << (HLF_EXP_W - 1)) - 1;
   localparam int DROP_W     = SGL_FRAC_W - HLF_FRAC_W;
   // biased single exponent limits for each result class
   localparam int SUB_LIM    = SGL_BIAS - HLF_BIAS + 1;     // first normal
   localparam int ZERO_LIM   = SUB_LIM - HLF_FRAC_W;        // first subnormal
   localparam int NORM_LIM   = SGL_BIAS + HLF_BIAS + 1;     // first overflow

   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'd0,
      RM_TO_ZERO   = 2'd1,
      RM_DOWN      = 2'd2,
      RM_UP        = 2'd3
   } rmode_e;

   typedef enum logic [2:0] {
      CL_ZERO, CL_SUB, CL_NORM, CL_OVF, CL_SPEC
   } rclass_e;
endpackage

// File: rtl/f2h_round.sv
module f2h_round
   import f2h_pkg::*;
(
   input  logic [SGL_W-1:0] src,
   input  rmode_e           mode,
   output logic             inc,
   output logic [SGL_W-2:0] rounded
);
   localparam int EXP_LO = SGL_FRAC_W;

   logic [SGL_EXP_W-1:0] exp_f;
   logic                 sgn, eligible, lsb_b, grd_b, rnd_b, stk_b, any_drop, want;

   always_comb begin
      exp_f    = src[SGL_W-2:EXP_LO];
      sgn      = src[SGL_W-1];
      eligible = (exp_f != '0) && (exp_f != '1);
      lsb_b    = src[DROP_W];
      grd_b    = src[DROP_W-1];
      rnd_b    = src[DROP_W-2];
      stk_b    = |src[DROP_W-3:0];
      any_drop = grd_b | rnd_b | stk_b;
      unique case (mode)
         RM_NEAR_EVEN: want = grd_b & (lsb_b | rnd_b | stk_b);
         RM_TO_ZERO:   want = 1'b0;
         RM_DOWN:      want = any_drop & sgn;
         RM_UP:        want = any_drop & ~sgn;
         default:      want = 1'b0;
      endcase
      inc     = eligible & want;
      rounded = src[SGL_W-2:0] + ((SGL_W-1)'(inc) << DROP_W);
   end
endmodule

// File: rtl/f2h_classify.sv
module f2h_classify
   import f2h_pkg::*;
(
   input  logic [SGL_EXP_W-1:0]  exp_r,
   input  logic [HLF_FRAC_W-1:0] kept,
   output rclass_e               cls,
   output logic [HLF_W-2:0]      mag
);
   logic [3:0]            sub_sh;
   logic [HLF_FRAC_W:0]   sub_full;
   logic [HLF_EXP_W-1:0]  norm_exp;

   always_comb begin
      sub_sh   = 4'(8'(SUB_LIM) - exp_r);
      sub_full = {1'b1, kept} >> sub_sh;
      norm_exp = HLF_EXP_W'(exp_r - 8'(SUB_LIM - 1));
      if (exp_r == '1)                 cls = CL_SPEC;
      else if (exp_r < 8'(ZERO_LIM))   cls = CL_ZERO;
      else if (exp_r < 8'(SUB_LIM))    cls = CL_SUB;
      else if (exp_r < 8'(NORM_LIM))   cls = CL_NORM;
      else                             cls = CL_OVF;
      unique case (cls)
         CL_ZERO: mag = '0;
         CL_SUB:  mag = {{HLF_EXP_W{1'b0}}, sub_full[HLF_FRAC_W-1:0]};
         CL_NORM: mag = {norm_exp, kept};
         CL_OVF:  mag = {{HLF_EXP_W{1'b1}}, {HLF_FRAC_W{1'b0}}};
         default: mag = {{HLF_EXP_W{1'b1}}, kept};
      endcase
   end
endmodule

// File: rtl/f2h_narrow.sv
module f2h_narrow
   import f2h_pkg::*;
#(
   parameter int REG_OUT = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] in_word,
   input  logic [1:0]  rnd_mode,
   output logic [15:0] out_half
);
   if (SGL_W != 32 || HLF_W != 16) begin : g_bad_fmt
      $error("f2h_narrow: format widths must be 32 and 16");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("f2h_narrow: REG_OUT must be 0 or 1");
   end

   logic              inc;
   logic [SGL_W-2:0]  rounded;
   rclass_e           cls;
   logic [HLF_W-2:0]  mag;
   logic [HLF_W-1:0]  result;

   f2h_round u_round (
      .src     (in_word),
      .mode    (rmode_e'(rnd_mode)),
      .inc     (inc),
      .rounded (rounded)
   );

   f2h_classify u_class (
      .exp_r (rounded[SGL_W-2:SGL_FRAC_W]),
      .kept  (rounded[SGL_FRAC_W-1:DROP_W]),
      .cls   (cls),
      .mag   (mag)
   );

   assign result = {in_word[SGL_W-1], mag};

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) out_half <= '0;
         else        out_half <= result;
      end

      assert_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> out_half[15] == $past(in_word[31]));
      assert_no_round_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_word[30:23] == 8'h00 || in_word[30:23] == 8'hFF) |-> !inc);
      assert_zero_exp_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_word[30:23] == 8'h00) |=> out_half[14:0] == 15'h0);
      assert_trunc_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (rnd_mode == 2'd1) |-> !inc);
      assert_ovf_inf_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (cls == CL_OVF) |=> out_half[14:0] == 15'h7C00);
      assert_special_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (in_word[30:23] == 8'hFF) |=> (out_half[14:10] == 5'h1F) &&
                                       (out_half[9:0] == $past(in_word[22:13])));
      assert_sub_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (cls == CL_SUB) |=> (out_half[14:10] == 5'h0) && (out_half[9:0] != 10'h0));
      assert_reset_R12: assert property (@(posedge clk)
         !rst_n |=> out_half == 16'h0);
   end else begin : g_comb
      assign out_half = result;
   end
endmodule

// File: tb/f2h_narrow_tb.sv
module f2h_narrow_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] in_word = '0;
   logic [1:0]  rnd_mode = '0;
   logic [15:0] out_half;
   int          n_vec = 0;
   int          n_bad = 0;
   int          cycles = 0;
   logic [31:0] lfsr = 32'hACE1_2468;

   always #2.5 clk = ~clk;

   f2h_narrow u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_word  (in_word),
      .rnd_mode (rnd_mode),
      .out_half (out_half)
   );

   // arithmetic reference: mantissa with hidden bit, round, renormalise
   task automatic ref_model(input logic [31:0] x, input logic [1:0] m,
                            output logic [15:0] r, output string tag);
      int   e, keep, rem, inc;
      logic s;
      s = x[31];
      tag = "R9";
      if (x[30:23] == 8'hFF) begin
         r = {s, 5'h1F, x[22:13]}; tag = "R11"; return;
      end
      if (x[30:23] == 8'h00) begin
         r = {s, 15'h0}; tag = "R2"; return;
      end
      e    = int'(x[30:23]) - 127;
      keep = int'({1'b1, x[22:13]});
      rem  = int'(x[12:0]);
      inc  = 0;
      case (m)
         2'd0: inc = (rem > 4096 || (rem == 4096 && keep % 2 == 1)) ? 1 : 0;
         2'd1: inc = 0;
         2'd2: inc = (rem != 0 && s) ? 1 : 0;
         default: inc = (rem != 0 && !s) ? 1 : 0;
      endcase
      if (rem != 0) tag = (m == 2'd0) ? "R5" : (m == 2'd1) ? "R3" : "R4";
      keep = keep + inc;
      if (keep == 2048) begin keep = 1024; e = e + 1; tag = "R6"; end
      if (e < -24) begin r = {s, 15'h0}; if (tag == "R9") tag = "R7"; end
      else if (e < -14) begin
         r = {s, 5'h0, 10'(keep >> (-e - 14))}; if (tag == "R9") tag = "R8";
      end
      else if (e < 16) r = {s, 5'(e + 15), 10'(keep)};
      else begin r = {s, 15'h7C00}; if (tag == "R9") tag = "R10"; end
   endtask

   task automatic apply(input logic [31:0] x, input logic [1:0] m);
      logic [15:0] exp_v;
      string       tag;
      @(negedge clk);
      in_word  = x;
      rnd_mode = m;
      ref_model(x, m, exp_v, tag);
      @(posedge clk);
      #1;
      n_vec++;
      if (out_half[15] != x[31]) tag = "R1";
      if (out_half !== exp_v) begin
         n_bad++;
         $display("FAIL %s in=%h mode=%0d got=%h expected=%h", tag, x, m, out_half, exp_v);
      end
   endtask

   function automatic logic [31:0] step(input logic [31:0] v);
      return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
   endfunction

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [12:0] lows [8];
      lows[0] = 13'h0000; lows[1] = 13'h1000; lows[2] = 13'h0800; lows[3] = 13'h0001;
      lows[4] = 13'h1800; lows[5] = 13'h1001; lows[6] = 13'h0FFF; lows[7] = 13'h1FFF;
      repeat (3) @(posedge clk);
      #1;
      n_vec++;   // R12: reset state
      if (out_half !== 16'h0) begin
         n_bad++;
         $display("FAIL R12 reset got=%h expected=0000", out_half);
      end
      @(negedge clk);
      rst_n = 1'b1;
      // directed corners
      apply(32'h3F7FF000, 2'd0);  // R6 carry to 1.0
      apply(32'h477FF000, 2'd0);  // R6 carry into overflow -> R10
      apply(32'h477FE000, 2'd1);  // largest normal
      apply(32'h7F800001, 2'd0);  // R11 low-payload NaN -> inf
      apply(32'h7FC00000, 2'd3);  // R11 quiet NaN
      apply(32'hFF800000, 2'd2);  // R11 -inf
      apply(32'h80000000, 2'd3);  // R1 negative zero
      apply(32'h00400000, 2'd3);  // R2 single subnormal not rounded
      apply(32'h7F7FFFFF, 2'd1);  // R10 overflow under toward zero
      apply(32'h33800000, 2'd0);  // R8 smallest half subnormal
      apply(32'h33000000, 2'd3);  // R7 below range
      // boundary sweep over exponents, fractions, signs and modes
      for (int md = 0; md < 4; md++)
         for (int ex = 0; ex < 256; ex++) begin
            if (!(ex < 2 || (ex >= 100 && ex <= 146) || ex >= 252)) continue;
            for (int lo = 0; lo < 8; lo++)
               for (int hi = 0; hi < 3; hi++)
                  for (int sg = 0; sg < 2; sg++) begin
                     logic [9:0] kf;
                     kf = (hi == 0) ? 10'h000 : (hi == 1) ? 10'h3FF : lfsr[9:0];
                     lfsr = step(lfsr);
                     apply({1'(sg), 8'(ex), kf, lows[lo]}, 2'(md));
                  end
         end
      // random words
      for (int k = 0; k < 4000; k++) begin
         lfsr = step(lfsr);
         apply(lfsr, lfsr[5:4] ^ lfsr[1:0]);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule